// File: doc/BRIEF.md
# Shared Memory Bank Access Arbiter

This block sits between a group of processing elements and a single data memory bank. In one array instruction each element may raise a memory request. The arbiter captures all of them together, runs every load before any store, and serves the requests one at a time. The instruction therefore takes longer as more elements compete for the bank. Each phase that has at least one requester costs a fixed two-cycle setup plus one cycle per requester. A phase with no requester is skipped.

An element can take its address from its column's pointer register (direct mode) or supply the address itself (indirect mode). Before execution, the pointer registers are loaded with base addresses through a small configuration port. Every direct access then moves the pointer on by one 32-bit word, so that streaming code needs no address arithmetic of its own. The bank is a small internal array. Its access stream is driven out on a single-port memory interface so that it can be observed.

Top module: `bank_arbiter`

## Requirements
- R1: After an accepted start, `busy` is high from the next cycle through the cycle that shows `done`. A load or store phase with k>0 requesters takes 2 setup cycles with no access, then k access cycles. A phase with no requester takes no cycles.
- R2: All loads are served before any store. Within a phase, elements are served in ascending index, one per access cycle. An access cycle shows exactly one `grant` bit, with `mem_en`=1 and `mem_we`=1 only for stores.
- R3: Element i belongs to column i/(NPE/NCOL). In direct mode (`req_ind`=0) the access uses the column pointer as its address, and the pointer then grows by 4 modulo 2^AW. Two direct requesters of one column therefore receive consecutive words in service order.
- R4: In indirect mode (`req_ind`=1) the access uses the element's latched address, and no pointer changes.
- R5: `cfg_we` writes `cfg_base` into the pointer of column `cfg_col` while the block is idle. It is ignored while `busy` is high.
- R6: `done` is high for exactly one cycle, on the cycle after the last access. It shows the full request mask. If nothing was requested, that cycle is the first one after start and shows all zeros.
- R7: A load updates its element's `rdata` slice at the end of its access cycle with the word at byte address/4 modulo DEPTH. A store writes its latched `req_wdata` there. Loads see memory as it was before this instruction's stores.
- R8: `mem_addr` always has its two low bits at zero. An access whose address has either of its two low bits set raises `err`, which stays high until reset. The access still takes place at the aligned word.
- R9: `start` is ignored while `busy` is high. Request inputs are sampled only on the edge that accepts `start`.
- R10: After reset, the block is idle: `grant`, `done`, `err` and `rdata` are zero. Pointers and memory words are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Pointer configuration write |
| cfg_col | input | CIW | Column selected for configuration |
| cfg_base | input | AW | Base byte address to load |
| start | input | 1 | Begin one instruction's memory accesses |
| req | input | NPE | Per-element access request |
| req_store | input | NPE | 1 = store, 0 = load |
| req_ind | input | NPE | 1 = indirect address, 0 = column pointer |
| req_addr | input | NPE*AW | Per-element byte address for indirect mode |
| req_wdata | input | NPE*DW | Per-element store data |
| grant | output | NPE | Element being served this cycle |
| done | output | NPE | One-cycle completion mask |
| rdata | output | NPE*DW | Per-element load result |
| busy | output | 1 | Instruction in progress |
| err | output | 1 | Sticky misaligned-address flag |
| mem_en | output | 1 | Bank access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Word-aligned byte address |
| mem_wdata | output | DW | Write data |

## Verification
Once a start is accepted, the reference model in the bench lays out a timeline of what the outputs should show in every cycle. The first cycle after the accepting edge is the first setup cycle of the load phase. If there are no loads, it is the first setup cycle of the store phase, or the done cycle if there are no requests at all. `grant`, `mem_*`, `busy` and `done` are due in the very cycle their timeline entry names. `rdata` and `err` change on the edge that closes an access, so the model applies those effects only after it has compared that cycle. All comparisons take place on the falling edge, while the inputs change just after the rising edge, so a value is always read half a cycle after it settles.

// File: rtl/bank_arbiter.sv
module bank_arbiter #(
  parameter int NPE   = 4,
  parameter int NCOL  = 2,
  parameter int AW    = 12,
  parameter int DW    = 32,
  parameter int DEPTH = 32,
  localparam int CIW  = (NCOL > 1) ? $clog2(NCOL) : 1,
  localparam int IW   = (NPE > 1) ? $clog2(NPE) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CIW-1:0]    cfg_col,
  input  logic [AW-1:0]     cfg_base,
  input  logic              start,
  input  logic [NPE-1:0]    req,
  input  logic [NPE-1:0]    req_store,
  input  logic [NPE-1:0]    req_ind,
  input  logic [NPE*AW-1:0] req_addr,
  input  logic [NPE*DW-1:0] req_wdata,
  output logic [NPE-1:0]    grant,
  output logic [NPE-1:0]    done,
  output logic [NPE*DW-1:0] rdata,
  output logic              busy,
  output logic              err,
  output logic              mem_en,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [DW-1:0]     mem_wdata
);
  localparam int PEC = NPE / NCOL;
  localparam int MW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  typedef enum logic [2:0] {S_IDLE, S_LOVH, S_LACC, S_SOVH, S_SACC, S_FIN} st_t;

  st_t                      st;
  logic                     ovh;
  logic [NPE-1:0]           lpend, spend, reqm, indm;
  logic [NPE-1:0][AW-1:0]   addr_q;
  logic [NPE-1:0][DW-1:0]   wd_q, rd_q;
  logic [NCOL-1:0][AW-1:0]  ptr;
  logic [DW-1:0]            mem [DEPTH];
  logic                     err_q;

  logic                     acc;
  logic [NPE-1:0]           pend, pend_nx;
  logic [IW-1:0]            cur;
  logic [CIW-1:0]           cur_col;
  logic [AW-1:0]            eff_addr;
  logic [MW-1:0]            widx;
  logic                     dir;

  assign acc  = (st == S_LACC) || (st == S_SACC);
  assign pend = (st == S_SACC) ? spend : lpend;

  always_comb begin
    cur = '0;
    for (int i = NPE - 1; i >= 0; i--)
      if (pend[i]) cur = IW'(i);
  end

  assign cur_col  = CIW'(int'(cur) / PEC);
  assign dir      = !indm[cur];
  assign eff_addr = dir ? ptr[cur_col] : addr_q[cur];
  assign widx     = MW'(eff_addr[AW-1:2]);
  assign grant    = acc ? (NPE'(1) << cur) : '0;
  assign pend_nx  = pend & ~grant;

  assign mem_en    = acc;
  assign mem_we    = (st == S_SACC);
  assign mem_addr  = {eff_addr[AW-1:2], 2'b00};
  assign mem_wdata = wd_q[cur];
  assign done      = (st == S_FIN) ? reqm : '0;
  assign busy      = (st != S_IDLE);
  assign err       = err_q;
  assign rdata     = rd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      ovh   <= 1'b0;
      lpend <= '0;
      spend <= '0;
      reqm  <= '0;
      indm  <= '0;
      addr_q <= '0;
      wd_q  <= '0;
      ptr   <= '0;
      err_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE: begin
          if (cfg_we) ptr[cfg_col] <= cfg_base;
          if (start) begin
            lpend  <= req & ~req_store;
            spend  <= req & req_store;
            reqm   <= req;
            indm   <= req_ind;
            addr_q <= req_addr;
            wd_q   <= req_wdata;
            ovh    <= 1'b0;
            if (|(req & ~req_store))     st <= S_LOVH;
            else if (|(req & req_store)) st <= S_SOVH;
            else                         st <= S_FIN;
          end
        end
        S_LOVH, S_SOVH: begin
          ovh <= ~ovh;
          if (ovh) st <= (st == S_LOVH) ? S_LACC : S_SACC;
        end
        S_LACC, S_SACC: begin
          if (st == S_LACC) lpend <= pend_nx;
          else              spend <= pend_nx;
          if (dir) ptr[cur_col] <= ptr[cur_col] + AW'(4);
          if (eff_addr[1:0] != 2'b00) err_q <= 1'b1;
          if (pend_nx == '0) begin
            ovh <= 1'b0;
            st  <= (st == S_LACC && spend != '0) ? S_SOVH : S_FIN;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q <= '0;
      for (int w = 0; w < DEPTH; w++) mem[w] <= '0;
    end else begin
      if (st == S_LACC) rd_q[cur] <= mem[widx];
      if (st == S_SACC) mem[widx] <= wd_q[cur];
    end
  end

  logic [AW-1:0] ptr_sum;
  always_comb begin
    ptr_sum = '0;
    for (int c = 0; c < NCOL; c++) ptr_sum = ptr_sum + ptr[c];
  end

  // R2
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R1
  setup_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (!mem_en ##1 !mem_en));

  // R3
  ptr_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && dir) |=> (ptr_sum == $past(ptr_sum) + AW'(4)));

  // R4
  ptr_hold_ind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && !dir) |=> $stable(ptr));

  // R5
  cfg_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !mem_en) |=> $stable(ptr));

  // R6
  done_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|done) |=> (!busy && done == '0));

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

  // R9
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && st != S_FIN) |=> busy);
endmodule

// File: tb/bank_arbiter_bench.sv
module bank_arbiter_bench;
  localparam int NPE = 4, NCOL = 2, AW = 12, DW = 32, DEPTH = 32;
  localparam int PEC = NPE / NCOL;
  localparam int CIW = 1;
  localparam time CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0;
  logic [CIW-1:0] cfg_col = '0;
  logic [AW-1:0] cfg_base = '0;
  logic start = 0;
  logic [NPE-1:0] req = '0, req_store = '0, req_ind = '0;
  logic [NPE-1:0][AW-1:0] b_addr = '0;
  logic [NPE-1:0][DW-1:0] b_wd = '0;
  logic [NPE-1:0] grant, done;
  logic [NPE-1:0][DW-1:0] rdata;
  logic busy, err, mem_en, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  bank_arbiter #(.NPE(NPE), .NCOL(NCOL), .AW(AW), .DW(DW), .DEPTH(DEPTH)) u_bank_arbiter (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_col(cfg_col), .cfg_base(cfg_base),
    .start(start), .req(req), .req_store(req_store), .req_ind(req_ind),
    .req_addr(b_addr), .req_wdata(b_wd), .grant(grant), .done(done), .rdata(rdata),
    .busy(busy), .err(err), .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata));

  typedef struct {
    logic [NPE-1:0] g;
    bit en, we, mis;
    logic [AW-1:0] a;
    logic [DW-1:0] wd;
    logic [NPE-1:0] dn;
    int ldi;
    logic [DW-1:0] ldv;
  } ent_t;

  ent_t q[$];
  logic [AW-1:0] rptr [NCOL];
  logic [DW-1:0] rmem [DEPTH];
  logic [DW-1:0] rrd [NPE];
  bit rerr;
  int checks = 0, fails = 0, cyc = 0;

  initial begin
    for (int c = 0; c < NCOL; c++) rptr[c] = '0;
    for (int w = 0; w < DEPTH; w++) rmem[w] = '0;
    for (int i = 0; i < NPE; i++) rrd[i] = '0;
    rerr = 0;
  end

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %h expected %h", tag, cyc, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  function automatic ent_t blank();
    ent_t e;
    e.g = '0; e.en = 0; e.we = 0; e.mis = 0; e.a = '0; e.wd = '0;
    e.dn = '0; e.ldi = -1; e.ldv = '0;
    return e;
  endfunction

  function automatic void phase(bit stores);
    ent_t e;
    int n = 0;
    for (int i = 0; i < NPE; i++) if (req[i] && (req_store[i] == stores)) n++;
    if (n == 0) return;
    q.push_back(blank());
    q.push_back(blank());
    for (int i = 0; i < NPE; i++) begin
      if (req[i] && (req_store[i] == stores)) begin
        logic [AW-1:0] eff;
        int col = i / PEC;
        int w;
        if (req_ind[i]) eff = b_addr[i];
        else begin
          eff = rptr[col];
          rptr[col] = rptr[col] + AW'(4);
        end
        w = int'(eff >> 2) % DEPTH;
        e = blank();
        e.g = NPE'(1) << i; e.en = 1; e.we = stores;
        e.a = {eff[AW-1:2], 2'b00}; e.mis = (eff[1:0] != 0);
        if (stores) begin
          e.wd = b_wd[i];
          rmem[w] = b_wd[i];
        end else begin
          e.ldi = i; e.ldv = rmem[w];
        end
        q.push_back(e);
      end
    end
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      ent_t e;
      bit eb;
      e = blank();
      eb = (q.size() > 0);
      if (eb) e = q.pop_front();
      chk(busy == eb, "R1 busy", 64'(busy), 64'(eb));
      chk(mem_en == e.en, "R1 mem_en", 64'(mem_en), 64'(e.en));
      chk(grant == e.g, "R2 grant", 64'(grant), 64'(e.g));
      if (e.en) begin
        chk(mem_we == e.we, "R2 mem_we", 64'(mem_we), 64'(e.we));
        chk(mem_addr == e.a, "R3 R4 R8 mem_addr", 64'(mem_addr), 64'(e.a));
        if (e.we) chk(mem_wdata == e.wd, "R7 mem_wdata", 64'(mem_wdata), 64'(e.wd));
      end
      chk(done == e.dn, "R6 done", 64'(done), 64'(e.dn));
      for (int i = 0; i < NPE; i++)
        chk(rdata[i] == rrd[i], "R7 rdata", 64'(rdata[i]), 64'(rrd[i]));
      chk(err == rerr, "R8 err", 64'(err), 64'(rerr));
      if (e.ldi >= 0) rrd[e.ldi] = e.ldv;
      if (e.mis) rerr = 1;
      if (!eb) begin
        if (cfg_we) rptr[cfg_col] = cfg_base;
        if (start) begin
          ent_t f;
          phase(0);
          phase(1);
          f = blank();
          f.dn = req;
          q.push_back(f);
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  task automatic cfg(int col, int base);
    @(posedge clk); #1;
    cfg_we = 1; cfg_col = CIW'(col); cfg_base = AW'(base);
    @(posedge clk); #1;
    cfg_we = 0;
  endtask

  task automatic issue(logic [NPE-1:0] r, logic [NPE-1:0] s, logic [NPE-1:0] ind, int hold);
    @(posedge clk); #1;
    req = r; req_store = s; req_ind = ind; start = 1;
    repeat (hold) @(posedge clk);
    #1;
    start = 0;
    req = ~r; req_store = ~s; b_addr = ~b_addr; b_wd = ~b_wd;
    repeat (16) @(posedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (3) @(posedge clk);
    // R10 reset state checked by the per-cycle comparison; R5 configuration
    cfg(0, 'h100);
    cfg(1, 'h204);
    // R2 R3 four direct stores
    for (int i = 0; i < NPE; i++) b_wd[i] = 32'hA000_0000 + i;
    issue(4'b1111, 4'b1111, 4'b0000, 1);
    // R7 reload pointers and read back
    cfg(0, 'h100);
    cfg(1, 'h204);
    issue(4'b1111, 4'b0000, 4'b0000, 1);
    // R4 R7 indirect store and load to same word, loads first
    b_addr = '0; b_addr[0] = 'h100; b_addr[1] = 'h100; b_wd = '0; b_wd[1] = 32'h5555_AAAA;
    issue(4'b0111, 4'b0010, 4'b0011, 1);
    // R8 misaligned indirect load
    b_addr = '0; b_addr[3] = 'h106;
    issue(4'b1000, 4'b0000, 4'b1000, 1);
    // R6 no requests
    issue(4'b0000, 4'b0000, 4'b0000, 1);
    // R9 start held while busy, R5 configuration while busy
    b_wd = '0; b_wd[2] = 32'h1234_5678;
    fork
      issue(4'b0100, 4'b0100, 4'b0000, 4);
      begin
        @(posedge clk); @(posedge clk); #2;
        cfg_we = 1; cfg_col = 1; cfg_base = 'h3F0;
        @(posedge clk); #1 cfg_we = 0;
      end
    join
    // R3 pointer wrap, two direct elements of one column
    cfg(1, 'hFFC);
    b_wd = '0; b_wd[2] = 32'hCAFE_0002; b_wd[3] = 32'hCAFE_0003;
    issue(4'b1100, 4'b1100, 4'b0000, 1);
    cfg(1, 'hFFC);
    issue(4'b1100, 4'b0000, 4'b0000, 1);
    // R1 single requester, mixed phases
    b_addr = '0; b_addr[0] = 'h008; b_wd = '0; b_wd[3] = 32'h0BAD_F00D;
    issue(4'b1001, 4'b1000, 4'b0001, 1);
    repeat (4) @(posedge clk);
    summary();
    $finish;
  end
endmodule